// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of Ethernet PHYs through two writable registers: a packed command word and a 16-bit data word. Writing the command word with its start/busy bit set launches one clause-22 read or write frame to the chosen PHY and register. The block shifts the frame out on MDC/MDIO, owns the MDIO output enable, and sets the busy bit back to zero when the frame is over. The host polls that bit to know when the data word holds read data, or when the next access may start.

The MDC frequency comes from a 4-bit clock-range code in the command word, which selects a fixed divide ratio of the system clock. A command write with the busy bit clear starts no frame. It still produces one full MDC pulse, so that a PHY that needs an MDC edge to leave reset can do so. Both registers are always visible on output ports.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command word and the data word read 0, MDC is low and the MDIO output enable is low.
- R2: The command word holds the PHY address in bits 15:11, the register number in bits 10:6, the clock-range code in bits 5:2, the direction in bit 1 (1 = write, 0 = read) and busy in bit 0. These fields read back as written. Busy reads 1 from the clock edge that accepts a starting write.
- R3: Busy returns to 0 exactly 64 MDC periods after the clock edge that accepted the starting write.
- R4: One MDC period lasts 42, 62, 16, 26, 102 or 124 system clocks for range codes 0 to 5. Any other code gives 124. MDC is low whenever no frame and no reset pulse is running.
- R5: A frame is 32 ones, then 01, then the opcode (10 read, 01 write), then the PHY address and the register number (each MSB first), then a 2-bit turnaround, then 16 data bits MSB first.
- R6: A write frame drives turnaround 10 and sends the data word as it stood when the frame was accepted. A data-word write during the frame does not change the bits sent, but it is visible in the data word.
- R7: In a read frame the MDIO output enable is low from the first turnaround bit to the end of the frame. The 16 bits sampled from the PHY are in the data word by the time busy reads 0.
- R8: The master changes its MDIO output only on falling MDC edges, and samples MDIO on rising MDC edges.
- R9: A command write with busy clear starts no frame: busy stays 0, the output enable stays low, and MDC makes exactly one rising edge before it returns low.
- R10: A command write that arrives while a frame or a reset pulse is running is ignored. The command fields, the running frame and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = command word, 1 = data word |
| wr_data_i | input | 16 | Register write value |
| cmd_o | output | 16 | Command word readback |
| data_o | output | 16 | Data word readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
Random reads and writes with random PHY addresses, register numbers and data run at the faster range codes. A PHY responder decodes every frame bit by bit, which separates field-order and opcode errors from data errors and from timing errors. Directed runs cover the slow codes and an undefined code, to tell the divide table apart from its default. Mid-frame intrusions (a command write, and a data write during a write frame) separate a snapshot taken at launch from a live register, and show that a command write during a frame is ignored. Reset pulses, with a starting write made during the pulse, show that MDC toggles once while MDIO stays quiet.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int CR_W       = 4;
  localparam int HALF_W     = 7;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_BITS = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regno;
    logic [CR_W-1:0]   cr;
    logic              wr;
    logic              busy;
  } cmd_t;

  // half of the MDC period in system clocks
  function automatic logic [HALF_W-1:0] mdc_half(input logic [CR_W-1:0] code);
    case (code)
      4'd0:    return HALF_W'(21);
      4'd1:    return HALF_W'(31);
      4'd2:    return HALF_W'(8);
      4'd3:    return HALF_W'(13);
      4'd4:    return HALF_W'(51);
      default: return HALF_W'(62);
    endcase
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              mdc_q;
  logic              wrap;

  assign wrap   = run_i && (cnt_q == half_i - HALF_W'(1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  a_r4_mdc_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(PRE_LEN + 4 + 2 * ADDR_W);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(PRE_LEN + 6 + 2 * ADDR_W);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] tx_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  active_q;
  logic                  rd_q;
  logic [DATA_W-1:0]     rdata_q;

  assign done_o    = active_q && fall_i && (idx_q == LAST_POS);
  assign mdio_o    = tx_q[FRAME_BITS-1];
  assign mdio_oe_o = active_q && !(rd_q && idx_q >= TA_POS);
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '1;
      idx_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (start_i) begin
        tx_q     <= {{PRE_LEN{1'b1}}, 2'b01, (write_i ? 2'b01 : 2'b10),
                     phy_i, reg_i, 2'b10, wdata_i};
        idx_q    <= '0;
        active_q <= 1'b1;
        rd_q     <= !write_i;
      end else if (active_q && fall_i) begin
        if (idx_q == LAST_POS) begin
          active_q <= 1'b0;
        end else begin
          tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b1};
          idx_q <= idx_q + IDX_W'(1);
        end
      end
      if (active_q && rise_i && rd_q && idx_q >= DATA_POS)
        rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
    end
  end

  // output bit moves only on a falling MDC strobe
  a_r8_out_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !fall_i && !start_i) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] cmd_o,
  output logic [15:0] data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  cmd_t              cmd_q;
  cmd_t              cmd_in;
  logic [DATA_W-1:0] data_q;
  logic              pulse_q;
  logic              accept, launch;
  logic              run, rise, fall;
  logic              frame_done;
  logic [DATA_W-1:0] rdata;

  assign cmd_in = cmd_t'(wr_data_i);
  assign accept = wr_en_i && !wr_sel_i && !cmd_q.busy && !pulse_q;
  assign launch = accept && cmd_in.busy;
  assign run    = cmd_q.busy || pulse_q;
  assign cmd_o  = cmd_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      data_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (accept) begin
        cmd_q   <= cmd_in;
        pulse_q <= !cmd_in.busy;
      end else begin
        if (pulse_q && fall) pulse_q <= 1'b0;
        if (frame_done)      cmd_q.busy <= 1'b0;
      end
      if (frame_done && !cmd_q.wr)
        data_q <= rdata;
      else if (wr_en_i && wr_sel_i)
        data_q <= wr_data_i;
    end
  end

  mdio_mdc_gen #(.HALF_W(HALF_W)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (mdc_half(cmd_q.cr)),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (launch),
    .write_i   (cmd_in.wr),
    .phy_i     (cmd_in.phy),
    .reg_i     (cmd_in.regno),
    .wdata_i   (data_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (rdata),
    .done_o    (frame_done)
  );

  a_r10_cmd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q.busy && !frame_done) |=> ($stable(cmd_q.phy) && $stable(cmd_q.regno)
                                     && $stable(cmd_q.cr) && $stable(cmd_q.wr) && cmd_q.busy));
  a_r9_pulse_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !mdio_oe_o);
  a_r3_done_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |-> cmd_q.busy);
  a_r4_idle_mdc_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !$past(run)) |-> !mdc_o);
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] cmd_o, data_o;
  logic        mdc, mdio_out, mdio_oe, mdio_in;
  logic        phy_drv = 1'b1;

  always #5 clk = ~clk;
  assign mdio_in = mdio_oe ? mdio_out : phy_drv;

  mdio_mgmt_master uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cmd_o(cmd_o), .data_o(data_o), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int ratio(input logic [3:0] c);
    case (c)
      4'd0: return 42; 4'd1: return 62; 4'd2: return 16;
      4'd3: return 26; 4'd4: return 102; default: return 124;
    endcase
  endfunction

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, ~p, r[0]} ^ 16'h3C5A;
  endfunction

  function automatic logic [63:0] exp_frame(input bit w, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10, d};
  endfunction

  // PHY responder and edge monitors
  int          pcnt = 64, frames_seen = 0, rises = 0, oe_err = 0, r8_err = 0;
  logic [63:0] psh = '0, p_frame = '0;
  bit          p_read = 0;
  logic [4:0]  p_phy = '0, p_reg = '0;
  logic        held = 1'b1;

  always @(posedge mdio_oe) begin pcnt = 0; p_read = 0; end

  always @(posedge mdc) begin
    held = mdio_out;
    rises++;
    if (pcnt < 64) begin
      if (p_read && pcnt >= 46 && mdio_oe) oe_err++;
      if (!p_read && pcnt < 46 && !mdio_oe) oe_err++;
      psh = {psh[62:0], mdio_in};
      pcnt++;
      if (pcnt == 36) p_read = (psh[1:0] == 2'b10);
      if (pcnt == 46) {p_phy, p_reg} = psh[9:0];
      if (pcnt == 64) begin p_frame = psh; frames_seen++; end
    end
  end

  always @(negedge mdc) begin
    if (p_read && pcnt == 47) phy_drv = 1'b0;
    else if (p_read && pcnt >= 48 && pcnt <= 63) phy_drv = phy_val(p_phy, p_reg)[63-pcnt];
    else phy_drv = 1'b1;
  end

  always @(negedge clk) if (rst_n && mdc && mdio_out !== held) r8_err++;

  task automatic write_reg(input bit sel, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_op(input bit w, input logic [4:0] p, input logic [4:0] r,
                        input logic [3:0] cr, input logic [15:0] wd,
                        input bit intr, input bit isel, input logic [15:0] ival);
    int n = 0;
    int fs0 = frames_seen;
    logic [15:0] cmd = {p, r, cr, w, 1'b1};
    logic [63:0] ef = exp_frame(w, p, r, wd);
    if (w) write_reg(1'b1, wd);
    write_reg(1'b0, cmd);
    chk(cmd_o == cmd, "R2 busy set", 64'(cmd_o), 64'(cmd));
    while (cmd_o[0] && n < 20000) begin
      @(negedge clk); n++;
      if (intr && n == 100) begin wr_en = 1'b1; wr_sel = isel; wr_data = ival; end
      if (intr && n == 101) begin
        wr_en = 1'b0;
        if (!isel) chk(cmd_o == cmd, "R10 cmd ignored", 64'(cmd_o), 64'(cmd));
      end
    end
    chk(n == 64 * ratio(cr), "R3 R4 busy time", 64'(n), 64'(64 * ratio(cr)));
    chk(cmd_o == {p, r, cr, w, 1'b0}, "R2 readback", 64'(cmd_o), 64'({p, r, cr, w, 1'b0}));
    chk(frames_seen == fs0 + 1, "R5 one frame", 64'(frames_seen), 64'(fs0 + 1));
    chk(mdc == 1'b0, "R4 idle low", 64'(mdc), 64'(0));
    if (w) begin
      chk(p_frame == ef, "R5 R6 write frame", p_frame, ef);
      chk(data_o == ((intr && isel) ? ival : wd), "R6 data word",
          64'(data_o), 64'((intr && isel) ? ival : wd));
    end else begin
      chk(p_frame[63:18] == ef[63:18], "R5 read header", 64'(p_frame[63:18]), 64'(ef[63:18]));
      chk(data_o == phy_val(p, r), "R7 read data", 64'(data_o), 64'(phy_val(p, r)));
    end
  endtask

  task automatic reset_pulse(input logic [3:0] cr);
    int r0 = rises;
    bit oe_seen = 0;
    logic [15:0] cmd = {5'h3, 5'h4, cr, 1'b1, 1'b0};
    write_reg(1'b0, cmd);
    chk(cmd_o[0] == 1'b0, "R9 busy stays 0", 64'(cmd_o[0]), 64'(0));
    for (int n = 1; n <= 2 * ratio(cr) + 8; n++) begin
      @(negedge clk);
      if (mdio_oe) oe_seen = 1;
      if (n == 3) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'hFFFF; end
      if (n == 4) wr_en = 1'b0;
    end
    chk(rises - r0 == 1, "R9 one MDC edge", 64'(rises - r0), 64'(1));
    chk(!oe_seen, "R9 R10 no frame", 64'(oe_seen), 64'(0));
    chk(cmd_o == cmd, "R10 write during pulse", 64'(cmd_o), 64'(cmd));
    chk(mdc == 1'b0, "R4 MDC low after pulse", 64'(mdc), 64'(0));
  endtask

  initial begin
    #(190000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] crs;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_o == 16'h0 && data_o == 16'h0, "R1 registers", {cmd_o, data_o}, 64'(0));
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", 64'({mdc, mdio_oe}), 64'(0));

    run_op(1'b0, 5'd1, 5'd2, 4'd5, 16'h0, 0, 0, 16'h0);
    run_op(1'b1, 5'd31, 5'd31, 4'd9, 16'hA55A, 0, 0, 16'h0);
    run_op(1'b0, 5'd0, 5'd0, 4'd4, 16'h0, 0, 0, 16'h0);
    run_op(1'b1, 5'd7, 5'd18, 4'd1, 16'h8001, 0, 0, 16'h0);
    run_op(1'b0, 5'd9, 5'd3, 4'd2, 16'h0, 1, 0, 16'hFFFF);
    run_op(1'b1, 5'd17, 5'd12, 4'd2, 16'h1234, 1, 0, 16'hFFFF);
    run_op(1'b1, 5'd5, 5'd6, 4'd3, 16'hC0DE, 1, 1, 16'h7E7E);
    reset_pulse(4'd2);
    reset_pulse(4'd0);

    for (int i = 0; i < 14; i++) begin
      case ($urandom % 3)
        0: crs = 4'd0;
        1: crs = 4'd2;
        default: crs = 4'd3;
      endcase
      run_op(1'($urandom % 2), 5'($urandom), 5'($urandom), crs, 16'($urandom), 0, 0, 16'h0);
    end

    chk(oe_err == 0, "R7 output enable", 64'(oe_err), 64'(0));
    chk(r8_err == 0, "R8 output change on MDC high", 64'(r8_err), 64'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule